// File: doc/BRIEF.md
# Microsecond Reload Timer with Sticky Interrupt

This block is a down-counter that advances once per microsecond tick and reports each time its count runs out. Software sets it up through a single control word that holds the run enable, the auto-reload choice and the reload count. A second word reads back the live count together with a sticky interrupt flag, which software clears by writing a one to the flag position. The tick is a clock-enable that comes from outside the block.

Every expiry sets the flag and also gives a one-cycle pulse on a separate output, so a neighbouring watchdog can count expiries whether or not software has cleared the flag. In auto-reload mode the counter starts again from the reload count after each expiry and keeps running. In single-shot mode it stops and drops its own enable bit. Register access goes through a plain word-addressed write and read port. Read data is registered.

Top module: `tick_reload_timer`

## Requirements
- R1: After a synchronous reset, both registers read back as zero, and `irq` and `expire_pulse` are low.
- R2: A write to byte offset 0x0 stores the enable bit from bit 31, the auto-reload bit from bit 30 and the reload count from bits 28:0. Bit 29 reads back as zero. The same write loads the live count with the reload count, or with 1 when the reload count is 0.
- R3: The live count drops by one only on a cycle where `tick_en` is high and the timer is enabled. On every other cycle it holds its value.
- R4: In auto-reload mode (bit 30 = 1), a tick that finds the count at 1 reloads the count from the stored reload value (0 counts as 1), and the timer keeps running.
- R5: In single-shot mode (bit 30 = 0), a tick that finds the count at 1 sets the count to 0 and clears the enable bit at offset 0x0. No further expiry occurs until software writes offset 0x0 again.
- R6: Each expiry sets the interrupt flag. The flag reads as bit 30 at offset 0x4, drives the `irq` output, and stays set until software clears it.
- R7: `expire_pulse` is high for exactly the cycle after each expiry tick. That is the same cycle in which the flag first reads as set, and the pulse occurs even if the flag was already set.
- R8: A write to offset 0x4 with bit 30 = 1 clears the flag. A write to offset 0x4 with bit 30 = 0 leaves the flag unchanged. The other bits written to offset 0x4 are ignored.
- R9: When an expiry and a flag-clearing write fall in the same cycle, the flag ends up set.
- R10: Writing zero to offset 0x0 stops the timer. Ticks then cause no decrement and no expiry, and the count reads back as 1.
- R11: When a write to offset 0x0 and a tick fall in the same cycle, the write wins. The count takes the new reload value and no decrement or expiry happens.
- R12: A read returns its data one cycle later on `bus_rdata`, which holds that value until the next read. Offset 0x4 returns the count in bits 28:0 and the flag in bit 30, with the other bits zero. Offsets 0x8 and 0xC read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle microsecond tick enable |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; bits above 1 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Sticky interrupt flag |
| expire_pulse | output | 1 | One-cycle pulse per expiry |

## Verification
Two pairs of functions can meet in one cycle. The first pair is an expiry tick and a software write of one to the flag. The second pair is a tick and a rewrite of the control word. The bench steers the count to 1, then presents the tick together with the clear write or the control write in the same cycle. It judges the result by the flag level, the pulse and the count read back afterwards, which must show the set flag and the newly loaded count. A long stretch of random ticks, clears and rewrites with small reload counts makes these overlaps happen many more times. A behavioural model is compared against the outputs every cycle during that stretch.

// File: rtl/trt_pkg.sv
package trt_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned EN_POS      = 31;
  localparam int unsigned MODE_POS    = 30;
  localparam int unsigned FLAG_POS    = 30;
  localparam int unsigned PERIOD_SLOT = 0;
  localparam int unsigned STATUS_SLOT = 1;

  typedef struct packed {
    logic run;
    logic autoload;
  } ctrl_t;
endpackage

// File: rtl/trt_regs.sv
module trt_regs
  import trt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              disarm,
  input  logic              expire,
  input  logic [CNT_W-1:0]  count,
  input  logic              flag,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              clr_req,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned SLOT_W = ADDR_W - 2;

  logic [SLOT_W-1:0] slot;
  logic              hit_period;
  logic              hit_status;
  logic [WORD_W-1:0] rd_word;
  logic              unused_bits;

  assign slot       = bus_addr[ADDR_W-1:2];
  assign hit_period = (slot == SLOT_W'(PERIOD_SLOT));
  assign hit_status = (slot == SLOT_W'(STATUS_SLOT));
  assign load       = bus_wr && hit_period;
  assign load_val   = bus_wdata[CNT_W-1:0];
  assign clr_req    = bus_wr && hit_status && bus_wdata[FLAG_POS];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[29:CNT_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (load) begin
      ctrl_q.run      <= bus_wdata[EN_POS];
      ctrl_q.autoload <= bus_wdata[MODE_POS];
      reload_q        <= load_val;
    end else if (disarm) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit_period) begin
      rd_word[EN_POS]      = ctrl_q.run;
      rd_word[MODE_POS]    = ctrl_q.autoload;
      rd_word[CNT_W-1:0]   = reload_q;
    end else if (hit_status) begin
      rd_word[FLAG_POS]    = flag;
      rd_word[CNT_W-1:0]   = count;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (bus_rd) begin
      rdata <= rd_word;
    end
  end

  // R10: a stopped timer never expires
  assert_stopped_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.run |-> !expire);

  // R2: a control write lands in the stored fields
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (ctrl_q.run == $past(bus_wdata[EN_POS])) && (reload_q == $past(load_val)));
endmodule

// File: rtl/trt_counter.sv
module trt_counter #(
  parameter int unsigned CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             run,
  input  logic             autoload,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count_q,
  output logic             expire,
  output logic             disarm
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] start_val(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic step;

  assign step   = run && tick_en && !load;
  assign expire = step && (count_q == ONE);
  assign disarm = expire && !autoload;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= start_val(load_val);
    end else if (expire) begin
      count_q <= autoload ? start_val(reload) : '0;
    end else if (step && count_q != '0) begin
      count_q <= count_q - ONE;
    end
  end

  // R3: without a tick or a load the count holds
  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !load) |=> $stable(count_q));

  // R2: a load never leaves a zero count
  assert_load_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (count_q != '0));
endmodule

// File: rtl/trt_irq.sv
module trt_irq (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic clr_req,
  output logic flag_q,
  output logic pulse_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= expire;
      if (expire) begin
        flag_q <= 1'b1;
      end else if (clr_req) begin
        flag_q <= 1'b0;
      end
    end
  end

  // R8: a clear without a competing expiry drops the flag
  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !expire) |=> !flag_q);

  // R9: an expiry always leaves the flag set, clear or not
  assert_expiry_wins_R9: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag_q);

  // R6: the flag is sticky until cleared
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_req) |=> flag_q);
endmodule

// File: rtl/tick_reload_timer.sv
module tick_reload_timer
  import trt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              expire_pulse
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             clr_req;
  logic [CNT_W-1:0] count_q;
  logic             expire;
  logic             disarm;
  logic             flag_q;
  logic             pulse_q;

  trt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .disarm    (disarm),
    .expire    (expire),
    .count     (count_q),
    .flag      (flag_q),
    .ctrl_q    (ctrl_q),
    .reload_q  (reload_q),
    .load      (load),
    .load_val  (load_val),
    .clr_req   (clr_req),
    .rdata     (bus_rdata)
  );

  trt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .run      (ctrl_q.run),
    .autoload (ctrl_q.autoload),
    .load     (load),
    .load_val (load_val),
    .reload   (reload_q),
    .count_q  (count_q),
    .expire   (expire),
    .disarm   (disarm)
  );

  trt_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .expire  (expire),
    .clr_req (clr_req),
    .flag_q  (flag_q),
    .pulse_q (pulse_q)
  );

  assign irq          = flag_q;
  assign expire_pulse = pulse_q;

  // R5: a single-shot expiry drops the enable
  assert_oneshot_disarm_R5: assert property (@(posedge clk) disable iff (rst)
    (expire && !ctrl_q.autoload) |=> !ctrl_q.run);

  // R7: the pulse coincides with a set flag
  assert_pulse_with_flag_R7: assert property (@(posedge clk) disable iff (rst)
    expire_pulse |-> irq);

  // R4: an auto-reload expiry keeps the timer running with a nonzero count
  assert_autoload_rerun_R4: assert property (@(posedge clk) disable iff (rst)
    (expire && ctrl_q.autoload && !load) |=> (ctrl_q.run && count_q != '0));
endmodule

// File: tb/tick_reload_timer_test.sv
module tick_reload_timer_test;
  logic        clk;
  logic        rst;
  logic        tick_en;
  logic        bus_wr;
  logic        bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        expire_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  tick_reload_timer #(.ADDR_W(4), .CNT_W(29)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .expire_pulse(expire_pulse)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  // behavioural reference model
  bit  m_en, m_per, m_flag, m_pulse;
  int  m_reload, m_cnt;
  int  m_rdata;

  function automatic int first_count(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_per = 0; m_flag = 0; m_pulse = 0;
      m_reload = 0; m_cnt = 0; m_rdata = 0;
    end else begin
      automatic int slot = int'(bus_addr) >> 2;
      automatic bit wr_ctrl = bus_wr && slot == 0;
      automatic bit wr_stat = bus_wr && slot == 1;
      automatic bit fire = m_en && tick_en && !wr_ctrl && m_cnt == 1;
      if (bus_rd) begin
        if (slot == 0) m_rdata = (int'(m_en) << 31) | (int'(m_per) << 30) | m_reload;
        else if (slot == 1) m_rdata = (int'(m_flag) << 30) | m_cnt;
        else m_rdata = 0;
      end
      if (wr_ctrl) begin
        m_en = bus_wdata[31];
        m_per = bus_wdata[30];
        m_reload = int'(bus_wdata[28:0]);
        m_cnt = first_count(m_reload);
      end else if (m_en && tick_en) begin
        if (m_cnt == 1) begin
          if (m_per) m_cnt = first_count(m_reload);
          else begin m_cnt = 0; m_en = 0; end
        end else m_cnt = m_cnt - 1;
      end
      if (fire) m_flag = 1;
      else if (wr_stat && bus_wdata[30]) m_flag = 0;
      m_pulse = fire;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (irq !== m_flag) begin
        bad++;
        $display("FAIL R6 irq actual=%0b expected=%0b at %0t", irq, m_flag, $time);
      end
      total++;
      if (expire_pulse !== m_pulse) begin
        bad++;
        $display("FAIL R7 expire_pulse actual=%0b expected=%0b at %0t", expire_pulse, m_pulse, $time);
      end
      total++;
      if (bus_rdata !== 32'(m_rdata)) begin
        bad++;
        $display("FAIL R12 rdata actual=%h expected=%h at %0t", bus_rdata, 32'(m_rdata), $time);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input bit t, input bit w, input logic [3:0] a,
                       input logic [31:0] d, input bit r);
    @(negedge clk);
    tick_en = t; bus_wr = w; bus_addr = a; bus_wdata = d; bus_rd = r;
  endtask

  task automatic idle();
    cycle(0, 0, 4'h0, 32'h0, 0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cycle(0, 1, a, d, 0);
    idle();
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    cycle(0, 0, a, 32'h0, 1);
    idle();
    v = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cycle(1, 0, 4'h0, 32'h0, 0);
    idle();
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rst = 1; tick_en = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst = 0;

    // R1: reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 pulse", {31'h0, expire_pulse}, 32'h0);
    rd(4'h0, v); check("R1 ctrl", v, 32'h0);
    rd(4'h4, v); check("R1 status", v, 32'h0);

    // R2: control write, bit 29 dropped, count loaded
    wr(4'h0, 32'hE000_0005);
    rd(4'h0, v); check("R2 ctrl readback", v, 32'hC000_0005);
    rd(4'h4, v); check("R2 count loaded", v, 32'h0000_0005);

    // R3: four ticks take 5 down to 1, idle cycles hold
    ticks(4);
    idle(); idle();
    rd(4'h4, v); check("R3 count after ticks", v, 32'h0000_0001);

    // R4, R6, R7: auto-reload expiry
    cycle(1, 0, 4'h0, 32'h0, 0);
    after_edge();
    check("R7 pulse on expiry", {31'h0, expire_pulse}, 32'h1);
    check("R6 irq on expiry", {31'h0, irq}, 32'h1);
    idle();
    after_edge();
    check("R7 pulse one cycle", {31'h0, expire_pulse}, 32'h0);
    rd(4'h4, v); check("R4 reload and flag", v, 32'h4000_0005);

    // R8: bit 30 clear only
    wr(4'h4, 32'hBFFF_FFFF);
    check("R8 zero bit no effect", {31'h0, irq}, 32'h1);
    wr(4'h4, 32'h4000_0000);
    check("R8 clear", {31'h0, irq}, 32'h0);

    // R9: expiry and clear in the same cycle
    ticks(4);
    cycle(1, 1, 4'h4, 32'h4000_0000, 0);
    after_edge();
    check("R9 flag kept", {31'h0, irq}, 32'h1);
    check("R9 pulse", {31'h0, expire_pulse}, 32'h1);
    idle();
    rd(4'h4, v); check("R9 status", v, 32'h4000_0005);

    // R11: control write beats a tick
    wr(4'h4, 32'h4000_0000);
    cycle(1, 1, 4'h0, 32'hC000_0003, 0);
    idle();
    rd(4'h4, v); check("R11 count from write", v, 32'h0000_0003);

    // R10: writing zero stops the timer
    wr(4'h0, 32'h0);
    ticks(10);
    rd(4'h4, v); check("R10 stopped count", v, 32'h0000_0001);
    check("R10 no irq", {31'h0, irq}, 32'h0);

    // R5: single shot
    wr(4'h0, 32'h8000_0002);
    ticks(2);
    rd(4'h0, v); check("R5 enable cleared", v, 32'h0000_0002);
    rd(4'h4, v); check("R5 count zero flag set", v, 32'h4000_0000);
    wr(4'h4, 32'h4000_0000);
    ticks(6);
    check("R5 no further expiry", {31'h0, irq}, 32'h0);

    // R12: unused slots
    rd(4'h8, v); check("R12 slot 8 reads zero", v, 32'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h0, v); check("R12 ctrl untouched", v, 32'h0000_0002);

    // R2, R4: reload of zero counts as one tick
    wr(4'h0, 32'hC000_0000);
    rd(4'h4, v); check("R2 zero reload count", v, 32'h0000_0001);
    ticks(1);
    rd(4'h4, v); check("R4 zero reload periodic", v, 32'h4000_0001);

    // random overlap stretch, checked by the model every cycle
    wr(4'h0, 32'hC000_0003);
    for (int i = 0; i < 4000; i++) begin
      automatic int r = $urandom_range(0, 15);
      automatic bit t = bit'($urandom_range(0, 1));
      if (r == 0)
        cycle(t, 1, 4'h0, {1'b1, bit'($urandom_range(0, 1)), 27'h0, 3'($urandom_range(0, 4))}, 0);
      else if (r == 1)
        cycle(t, 1, 4'h4, 32'h4000_0000, bit'($urandom_range(0, 1)));
      else if (r == 2)
        cycle(t, 1, 4'h4, 32'h0, 0);
      else if (r < 6)
        cycle(t, 0, 4'(4 * $urandom_range(0, 2)), 32'h0, 1);
      else
        cycle(t, 0, 4'h0, 32'h0, 0);
    end
    idle();
    idle();
    finish_run();
  end
endmodule